// File: doc/BRIEF.md
# Bank Switcher with Reloading Interrupt Down-Counter

This block sits on the CPU write path of a cartridge-style memory map. Writes to the upper half of the CPU address space, 0x8000 to 0xFFFF, are decoded on the four lowest address bits only. Every other address bit in that half is ignored, so each register appears many times across the window. The registers select eight 1 KB character banks and one 16 KB program bank for the window at 0x8000. A two-bit code picks one of four nametable mirroring arrangements. The 16 KB program window at 0xC000 always shows the last bank.

A 16-bit reload value is written one byte at a time. A control write copies the reload value into a down-counter, sets or clears counting, and retires any pending interrupt. While counting is on, the counter steps down once per clock. When it reaches zero it raises the interrupt line and stops counting. The interrupt line stays high until the next control write.

Top module: `bank_irq_ctrl`

## Requirements
- R1: A write takes effect only when `wr_en` is high and `addr[15]` is 1. Only `addr[3:0]` selects the register, so 0xFFF3 reaches the same register as 0x8003. Writes with `addr[15]` = 0 change no output.
- R2: A write to offset N, where N is 0 to 7, loads `wdata` into character slot N. Slot N covers character addresses N×0x400 and is output on `chr_banks[N*8 +: 8]`. The other slots keep their values.
- R3: A write to offset 8 loads `wdata` into `prg_lo_bank`. `prg_hi_bank` is all ones at all times.
- R4: A write to offset 9 sets `mirror_mode` to `wdata[1:0]` and ignores the other data bits. The codes are: 0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B.
- R5: Offset 0xB loads the low byte of the reload value and offset 0xC loads the high byte. Neither write changes a count that is already running.
- R6: A write to offset 0xA drops `irq` on the next clock, sets counting on or off from `wdata[0]`, and copies the reload value into the counter.
- R7: While counting is on, the counter decrements on each clock. When a control write with reload value L ≥ 1 enables counting, `irq` first reads high L clocks after the write edge. With L = 0 it reads high one clock after. Counting turns off when `irq` rises.
- R8: Once high, `irq` stays high through any clocks and any writes except a write to offset 0xA.
- R9: Writes to offsets 0xD, 0xE and 0xF have no effect on any output.
- R10: Synchronous reset makes all of these zero: the character banks, `prg_lo_bank`, `mirror_mode` (vertical), `irq`, counting, the counter and the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| chr_banks | output | CHR_SLOTS*CHR_W | Character bank numbers, slot N in bits N*CHR_W upward |
| prg_lo_bank | output | PRG_W | Program bank for 0x8000 |
| prg_hi_bank | output | PRG_W | Program bank for 0xC000, fixed to the last bank |
| mirror_mode | output | 2 | Mirroring code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench measures how many clocks the interrupt takes to rise for reload values of 5, 258 and 0. An off-by-one in the zero detect would show up as `irq` rising one clock early or late. A counter that wrapped on a zero reload would hold `irq` low for 65536 clocks.

Several cases target the reload path:
- Rewriting the reload bytes while a count runs. A design that copied the latch continuously would move the interrupt edge.
- A second control write part-way through a count must restart it.
- A control write with bit 0 clear must both drop the pending interrupt and keep it from returning.

Further cases cover the register decode and reset:
- Mirrored addresses, lower-half writes and the unused offsets would each corrupt a bank or mirroring output if decoded wrongly.
- Mirroring data with high bits set would leak into the code if the design used more than two bits.
- A reset while `irq` is high must clear everything.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int OFS_W   = 4;
    localparam int LATCH_W = 16;
    localparam int SLOT_W  = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_CHR,
        K_PRG,
        K_MIR,
        K_CTL,
        K_LAT_LO,
        K_LAT_HI
    } reg_kind_e;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORIZ = 2'd1,
        MIR_ONE_A = 2'd2,
        MIR_ONE_B = 2'd3
    } mirror_e;

    typedef struct packed {
        logic              hit;
        reg_kind_e         kind;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    // Register kind selected by the low address nibble.
    function automatic reg_kind_e kind_of(input logic [OFS_W-1:0] ofs);
        reg_kind_e k;
        if (!ofs[3]) begin
            k = K_CHR;
        end else begin
            case (ofs[2:0])
                3'd0:    k = K_PRG;
                3'd1:    k = K_MIR;
                3'd2:    k = K_CTL;
                3'd3:    k = K_LAT_LO;
                3'd4:    k = K_LAT_HI;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic mirror_e mirror_of(input logic [1:0] code);
        return mirror_e'(code);
    endfunction

endpackage

// File: rtl/bank_wr_decode.sv
module bank_wr_decode
    import bank_irq_pkg::*;
(
    input  logic                wr_en,
    input  logic                a15,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DATA_W-1:0]   wdata,
    output wr_cmd_t             cmd
);
    always_comb begin
        cmd.hit  = wr_en && a15;
        cmd.kind = cmd.hit ? kind_of(ofs) : K_NONE;
        cmd.slot = ofs[SLOT_W-1:0];
        cmd.data = wdata;
    end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
    import bank_irq_pkg::*;
#(
    parameter int CHR_SLOTS = 8,
    parameter int CHR_W     = 8,
    parameter int PRG_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_cmd_t                     cmd,
    output logic [CHR_SLOTS*CHR_W-1:0]  chr_banks,
    output logic [PRG_W-1:0]            prg_lo,
    output mirror_e                     mirror
);
    for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chr
        logic [CHR_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q <= '0;
            end else if (cmd.hit && cmd.kind == K_CHR && cmd.slot == SLOT_W'(i)) begin
                bank_q <= CHR_W'(cmd.data);
            end
        end
        assign chr_banks[i*CHR_W +: CHR_W] = bank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_lo <= '0;
            mirror <= MIR_VERT;
        end else if (cmd.hit) begin
            if (cmd.kind == K_PRG) prg_lo <= PRG_W'(cmd.data);
            if (cmd.kind == K_MIR) mirror <= mirror_of(cmd.data[1:0]);
        end
    end
endmodule

// File: rtl/irq_reload_latch.sv
module irq_reload_latch
    import bank_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [DATA_W-1:0]   data,
    output logic [LATCH_W-1:0]  value
);
    localparam int HALF = LATCH_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            if (lo_we) value[HALF-1:0]       <= HALF'(data);
            if (hi_we) value[LATCH_W-1:HALF] <= HALF'(data);
        end
    end
endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter
    import bank_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic                ctl_en,
    input  logic [LATCH_W-1:0]  reload,
    output logic                irq,
    output logic                run,
    output logic [LATCH_W-1:0]  count
);
    logic last_step;
    assign last_step = (count <= LATCH_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
            irq   <= 1'b0;
        end else if (ctl_we) begin
            count <= reload;
            run   <= ctl_en;
            irq   <= 1'b0;
        end else if (run) begin
            if (last_step) begin
                count <= '0;
                run   <= 1'b0;
                irq   <= 1'b1;
            end else begin
                count <= count - LATCH_W'(1);
            end
        end
    end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
    import bank_irq_pkg::*;
#(
    parameter int CHR_SLOTS = 8,
    parameter int CHR_W     = 8,
    parameter int PRG_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [15:0]                 addr,
    input  logic [7:0]                  wdata,
    output logic [CHR_SLOTS*CHR_W-1:0]  chr_banks,
    output logic [PRG_W-1:0]            prg_lo_bank,
    output logic [PRG_W-1:0]            prg_hi_bank,
    output logic [1:0]                  mirror_mode,
    output logic                        irq
);
    wr_cmd_t             cmd;
    mirror_e             mirror;
    logic [LATCH_W-1:0]  reload;
    logic [LATCH_W-1:0]  irq_cnt;
    logic                irq_en;
    logic                unused_addr_bits;

    assign unused_addr_bits = ^addr[ADDR_W-2:OFS_W];

    bank_wr_decode u_dec (
        .wr_en (wr_en),
        .a15   (addr[ADDR_W-1]),
        .ofs   (addr[OFS_W-1:0]),
        .wdata (wdata),
        .cmd   (cmd)
    );

    bank_regs #(
        .CHR_SLOTS (CHR_SLOTS),
        .CHR_W     (CHR_W),
        .PRG_W     (PRG_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .chr_banks (chr_banks),
        .prg_lo    (prg_lo_bank),
        .mirror    (mirror)
    );

    irq_reload_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .lo_we (cmd.kind == K_LAT_LO),
        .hi_we (cmd.kind == K_LAT_HI),
        .data  (cmd.data),
        .value (reload)
    );

    irq_down_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctl_we (cmd.kind == K_CTL),
        .ctl_en (cmd.data[0]),
        .reload (reload),
        .irq    (irq),
        .run    (irq_en),
        .count  (irq_cnt)
    );

    assign prg_hi_bank = '1;
    assign mirror_mode = mirror;
endmodule

// File: rtl/bank_irq_chk.sv
module bank_irq_chk
    import bank_irq_pkg::*;
#(
    parameter int CHR_SLOTS = 8,
    parameter int CHR_W     = 8,
    parameter int PRG_W     = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [15:0]                 addr,
    input logic [7:0]                  wdata,
    input logic [CHR_SLOTS*CHR_W-1:0]  chr_banks,
    input logic [PRG_W-1:0]            prg_lo_bank,
    input logic [1:0]                  mirror_mode,
    input logic                        irq,
    input logic                        cnt_en,
    input logic [LATCH_W-1:0]          cnt
);
    logic upper_wr, ctl_wr, prg_wr, mir_wr, dead_wr, lower_wr, unused_chk;

    assign upper_wr   = wr_en && addr[15];
    assign ctl_wr     = upper_wr && addr[3:0] == 4'hA;
    assign prg_wr     = upper_wr && addr[3:0] == 4'h8;
    assign mir_wr     = upper_wr && addr[3:0] == 4'h9;
    assign dead_wr    = upper_wr && addr[3:0] >= 4'hD;
    assign lower_wr   = wr_en && !addr[15];
    assign unused_chk = ^{addr, wdata};

    AST_LOWER_HALF_IGNORED: assert property (@(posedge clk) disable iff (rst)
        lower_wr |=> $stable(chr_banks) && $stable(prg_lo_bank) && $stable(mirror_mode)); // R1
    AST_PRG_LOAD: assert property (@(posedge clk) disable iff (rst)
        prg_wr |=> prg_lo_bank == PRG_W'($past(wdata))); // R3
    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (rst)
        mir_wr |=> mirror_mode == $past(wdata[1:0])); // R4
    AST_CTL_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> !irq); // R6
    AST_CTL_SETS_EN: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> cnt_en == $past(wdata[0])); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt > LATCH_W'(1) && !ctl_wr) |=> cnt == $past(cnt) - LATCH_W'(1)); // R7
    AST_IRQ_STOPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !cnt_en && cnt == '0); // R7
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl_wr) |=> irq); // R8
    AST_DEAD_OFS: assert property (@(posedge clk) disable iff (rst)
        dead_wr |=> $stable(chr_banks) && $stable(prg_lo_bank) && $stable(mirror_mode) && $stable(irq)); // R9
endmodule

bind bank_irq_ctrl bank_irq_chk #(
    .CHR_SLOTS (CHR_SLOTS),
    .CHR_W     (CHR_W),
    .PRG_W     (PRG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .chr_banks   (chr_banks),
    .prg_lo_bank (prg_lo_bank),
    .mirror_mode (mirror_mode),
    .irq         (irq),
    .cnt_en      (irq_en),
    .cnt         (irq_cnt)
);

// File: tb/bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module bank_irq_ctrl_tb;

    typedef struct {
        logic [63:0] chr;
        logic [7:0]  prg;
        logic [1:0]  mir;
        logic        irq;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [63:0] chr_banks;
    logic [7:0]  prg_lo_bank, prg_hi_bank;
    logic [1:0]  mirror_mode;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    item_t       sb_q[$];
    logic [63:0] exp_chr = '0;
    logic [7:0]  exp_prg = '0;
    logic [1:0]  exp_mir = '0;
    logic        exp_irq = 1'b0;

    always #2.5 clk = ~clk;

    bank_irq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .chr_banks   (chr_banks),
        .prg_lo_bank (prg_lo_bank),
        .prg_hi_bank (prg_hi_bank),
        .mirror_mode (mirror_mode),
        .irq         (irq)
    );

    task automatic push(input string tag);
        item_t it;
        it.chr = exp_chr; it.prg = exp_prg; it.mir = exp_mir; it.irq = exp_irq; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic model_apply(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) begin
            case (a[3:0])
                4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7:
                    exp_chr[a[2:0]*8 +: 8] = d;
                4'h8: exp_prg = d;
                4'h9: exp_mir = d[1:0];
                4'hA: exp_irq = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_apply(a, d);
        push(tag);
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        push(tag);
    endtask

    task automatic run_count(input int reload, input int from, input int upto, input string tag);
        int first;
        first = (reload == 0) ? 1 : reload;
        for (int j = from; j <= upto; j++) begin
            exp_irq = (j >= first);
            tick(tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_chr = '0; exp_prg = '0; exp_mir = '0; exp_irq = 1'b0;
    endtask

    // Monitor: pops one expected item per clock and compares it against the outputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (chr_banks !== it.chr || prg_lo_bank !== it.prg || prg_hi_bank !== 8'hFF ||
                mirror_mode !== it.mir || irq !== it.irq) begin
                fails++;
                $display("FAIL %s: act chr=%h prg=%h/%h mir=%0d irq=%b exp chr=%h prg=%h/ff mir=%0d irq=%b",
                         it.tag, chr_banks, prg_lo_bank, prg_hi_bank, mirror_mode, irq,
                         it.chr, it.prg, it.mir, it.irq);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        tick("R10 reset state");

        for (int i = 0; i < 8; i++)
            do_write(16'h8000 + 16'(i), 8'(8'h10 + i * 8'h11), "R2 char slot load");
        do_write(16'hFFF3, 8'hA5, "R1 mirrored address reaches slot 3");
        do_write(16'h7003, 8'h11, "R1 lower half ignored");
        do_write(16'h7FF9, 8'h03, "R1 lower half mirror ignored");

        do_write(16'hC008, 8'h3C, "R3 program bank load");
        do_write(16'h9AB8, 8'hC7, "R3 program bank via high alias");

        for (int m = 0; m < 4; m++)
            do_write(16'h8009, 8'(8'hFC | m), "R4 mirroring code");
        do_write(16'h8009, 8'hF5, "R4 high data bits ignored");

        do_write(16'h800D, 8'hFF, "R9 offset D ignored");
        do_write(16'h800E, 8'hFF, "R9 offset E ignored");
        do_write(16'hFFFF, 8'hFF, "R9 offset F ignored");

        do_write(16'h800B, 8'h05, "R5 latch low");
        do_write(16'h800C, 8'h00, "R5 latch high");
        do_write(16'h800A, 8'h01, "R6 enable and load");
        run_count(5, 1, 8, "R7 irq after 5 clocks");

        do_write(16'h800B, 8'h03, "R8 irq holds over latch write");
        tick("R8 irq holds");
        do_write(16'h800A, 8'h00, "R6 control write drops irq");
        for (int k = 0; k < 10; k++) tick("R6 disabled stays quiet");

        do_write(16'h800B, 8'h02, "R5 latch low 258");
        do_write(16'h800C, 8'h01, "R5 latch high 258");
        do_write(16'h800A, 8'h01, "R6 start 258");
        run_count(258, 1, 99, "R7 count 258");
        do_write(16'h800B, 8'h00, "R5 latch write mid count");
        run_count(258, 101, 262, "R5 running count unaffected");

        do_write(16'h800C, 8'h00, "R8 irq holds over latch high");
        do_write(16'h800A, 8'h01, "R6 reload zero");
        run_count(0, 1, 3, "R7 zero reload fires next clock");

        do_write(16'h800B, 8'h0A, "R5 latch 10");
        do_write(16'h800A, 8'h01, "R6 start 10");
        run_count(10, 1, 4, "R7 partial count");
        do_write(16'h800A, 8'h01, "R6 restart mid count");
        run_count(10, 1, 12, "R7 restarted count");

        do_reset();
        tick("R10 reset clears irq and banks");

        wait (sb_q.size() == 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule